// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block is a write-back data cache placed between a word-addressed processor port and a main-memory port that moves one word per acknowledge. A 16-bit word address divides into a tag, a set index and a word offset. Each of the 64 sets holds two lines of 16 words. Every line carries a tag, a valid flag and a dirty flag, and every set carries one replacement bit. Hits are served from the cache. A miss picks a victim line in the addressed set. If the victim is dirty, its 16 words go back to memory first. The line is then refilled one word at a time. For a read, the requested word reaches the processor as soon as it arrives. A write miss allocates the line before the word is overwritten. A separate invalidate input lets an external memory-to-disk transfer engine drop a resident line.

The controller is a three-state machine. ST_IDLE accepts requests and serves hits. ST_EVICT streams the dirty victim out. ST_REFILL streams the new line in. Its transitions are:
- idle-to-evict: a miss whose victim is valid and dirty.
- idle-to-refill: a miss whose victim is clean or empty.
- evict-to-refill: the acknowledge of the last written word.
- refill-to-idle: the acknowledge of the last read word.
- Every other case holds the current state.

Top module: `twoway_wb_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `mem_req` and `cpu_rvalid` are 0. The first access to any address therefore misses.
- R2: Address bits [15:10] are the tag, [9:4] the set index and [3:0] the word offset. Every memory address the block issues is {tag, set, offset} in that same layout.
- R3: A read hit raises `cpu_rvalid` with the word in the cycle after acceptance. It causes no memory traffic, and `cpu_ready` stays 1.
- R4: A write hit changes only the cache and marks the line dirty. The new word reaches memory only when that line is later evicted.
- R5: On a read miss, `cpu_rvalid` rises with the word in the cycle after the acknowledge that delivered the requested offset, even if later words of the line are still to come.
- R6: The victim is way 0 if way 0 is invalid, else way 1 if way 1 is invalid, else the least recently used way. Every hit and every fill makes the other way of that set the next candidate.
- R7: A dirty victim is written back as 16 memory writes to {old tag, set, 0..15} in ascending order, before any refill read. A clean or empty victim causes no write.
- R8: A write miss performs the full 16-word refill, then holds the written word in place of the fetched one and leaves the line dirty. Writes never raise `cpu_rvalid`.
- R9: A request is taken at a rising edge where `cpu_req` and `cpu_ready` are both 1. After a miss is taken, `cpu_ready` is 0 until the edge that takes the last refill acknowledge.
- R10: An invalidate pulse whose tag and set match a valid line clears that line, and any dirty data in it is dropped. The offset bits are ignored. A pulse that matches no line has no effect.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. Each acknowledge completes one word, and read data is taken from `mem_rdata` in the acknowledge cycle.
- R12: Refill reads always go from offset 0 up to offset 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Request can be taken this cycle |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 16 | Read data |
| mem_req | output | 1 | Memory word transfer pending |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completes one word |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| inv_req | input | 1 | Invalidate pulse |
| inv_addr | input | 16 | Address whose line is invalidated |

## Verification
The assertions watch, on every cycle, the properties that are local in time:
- at most one way matches a lookup;
- a fill leaves its line valid;
- `cpu_ready` drops after a taken miss;
- the memory request holds steady until acknowledged;
- offsets climb by one between acknowledges;
- the last writeback word hands over to the refill.

Only the bench's scenarios can show the properties that depend on history: which way LRU order evicts, that a write hit's data appears at a much later eviction, that the critical word arrives after the right number of acknowledges, and that an invalidated dirty line reads back the old memory contents.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
    parameter int TAG_W = 6,
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             vict_way,
    output logic             vict_valid,
    output logic             vict_dirty,
    output logic [TAG_W-1:0] vict_tag,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way,
    input  logic             op_touch,
    input  logic             op_dirty,
    input  logic             op_drop,
    input  logic             op_fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             inv_req,
    input  logic [SET_W-1:0] inv_set,
    input  logic [TAG_W-1:0] inv_tag
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 2;

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [SETS-1:0]  lru_q;
    logic [WAYS-1:0]  hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_way = hit_vec[1];
        if (!valid_q[lk_set][0])
            vict_way = 1'b0;
        else if (!valid_q[lk_set][1])
            vict_way = 1'b1;
        else
            vict_way = lru_q[lk_set];
        vict_valid = valid_q[lk_set][vict_way];
        vict_dirty = dirty_q[lk_set][vict_way];
        vict_tag   = tag_q[lk_set][vict_way];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (op_touch)
                lru_q[upd_set] <= ~upd_way;
            if (op_drop) begin
                valid_q[upd_set][upd_way] <= 1'b0;
                dirty_q[upd_set][upd_way] <= 1'b0;
            end
            if (op_dirty)
                dirty_q[upd_set][upd_way] <= 1'b1;
            if (op_fill) begin
                valid_q[upd_set][upd_way] <= 1'b1;
                dirty_q[upd_set][upd_way] <= fill_dirty;
            end
            if (inv_req) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (valid_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag)) begin
                        valid_q[inv_set][w] <= 1'b0;
                        dirty_q[inv_set][w] <= 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op_fill)
            tag_q[upd_set][upd_way] <= fill_tag;
    end

    // R6: a lookup never finds the same tag in both ways of a set
    p_onehot_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5: the line that was just filled is valid from the next cycle on
    p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_fill |=> valid_q[$past(upd_set)][$past(upd_way)]);
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_way,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic              rd_way,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = SET_W + 1 + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx  = {wr_set, wr_way, wr_off};
    assign rd_idx  = {rd_set, rd_way, rd_off};
    assign rd_data = word_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en)
            word_q[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import cache2w_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              hit,
    input  logic              hit_way,
    input  logic              vict_way,
    input  logic              vict_valid,
    input  logic              vict_dirty,
    input  logic [TAG_W-1:0]  vict_tag,
    output logic [SET_W-1:0]  upd_set,
    output logic              upd_way,
    output logic              op_touch,
    output logic              op_dirty,
    output logic              op_drop,
    output logic              op_fill,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              fill_dirty,
    output logic [SET_W-1:0]  rd_set,
    output logic              rd_way,
    output logic [OFF_W-1:0]  rd_off,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [SET_W-1:0]  wr_set,
    output logic              wr_way,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data
);
    localparam int WORDS = 1 << OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    ctrl_state_e state_q, state_d;

    logic [TAG_W-1:0]  cpu_tag;
    logic [SET_W-1:0]  cpu_set;
    logic [OFF_W-1:0]  cpu_off;
    logic              accept;
    logic              last_beat;

    logic              req_we_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [SET_W-1:0]  req_set_q;
    logic [OFF_W-1:0]  req_off_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              way_q;
    logic [TAG_W-1:0]  vtag_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    assign cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_set   = cpu_addr[OFF_W +: SET_W];
    assign cpu_off   = cpu_addr[OFF_W-1:0];
    assign accept    = cpu_req && (state_q == ST_IDLE);
    assign last_beat = mem_ack && (cnt_q == LAST_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !hit)
                    state_d = (vict_valid && vict_dirty) ? ST_EVICT : ST_REFILL;
            end
            ST_EVICT: begin
                if (last_beat)
                    state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (last_beat)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture, beat counter, processor read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_tag_q   <= '0;
            req_set_q   <= '0;
            req_off_q   <= '0;
            req_wdata_q <= '0;
            way_q       <= 1'b0;
            vtag_q      <= '0;
            cnt_q       <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rvalid_q <= 1'b0;
            if (accept) begin
                req_we_q    <= cpu_we;
                req_tag_q   <= cpu_tag;
                req_set_q   <= cpu_set;
                req_off_q   <= cpu_off;
                req_wdata_q <= cpu_wdata;
                way_q       <= vict_way;
                vtag_q      <= vict_tag;
                cnt_q       <= '0;
                if (hit && !cpu_we) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= rd_data;
                end
            end
            if ((state_q != ST_IDLE) && mem_ack)
                cnt_q <= cnt_q + 1'b1;
            if ((state_q == ST_REFILL) && mem_ack && (cnt_q == req_off_q) && !req_we_q) begin
                rvalid_q <= 1'b1;
                rdata_q  <= mem_rdata;
            end
        end
    end

    // outputs per state
    always_comb begin
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {vtag_q, req_set_q, cnt_q};
        mem_wdata  = rd_data;
        upd_set    = cpu_set;
        upd_way    = hit ? hit_way : vict_way;
        op_touch   = 1'b0;
        op_dirty   = 1'b0;
        op_drop    = 1'b0;
        op_fill    = 1'b0;
        fill_tag   = req_tag_q;
        fill_dirty = req_we_q;
        rd_set     = cpu_set;
        rd_way     = hit_way;
        rd_off     = cpu_off;
        wr_en      = 1'b0;
        wr_set     = cpu_set;
        wr_way     = hit_way;
        wr_off     = cpu_off;
        wr_data    = cpu_wdata;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (accept) begin
                    if (hit) begin
                        op_touch = 1'b1;
                        if (cpu_we) begin
                            op_dirty = 1'b1;
                            wr_en    = 1'b1;
                        end
                    end else begin
                        op_drop = 1'b1;
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                rd_set  = req_set_q;
                rd_way  = way_q;
                rd_off  = cnt_q;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag_q, req_set_q, cnt_q};
                wr_en    = mem_ack;
                wr_set   = req_set_q;
                wr_way   = way_q;
                wr_off   = cnt_q;
                wr_data  = (req_we_q && (cnt_q == req_off_q)) ? req_wdata_q : mem_rdata;
                upd_set  = req_set_q;
                upd_way  = way_q;
                if (last_beat) begin
                    op_fill  = 1'b1;
                    op_touch = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;

    // R9: a taken miss closes the processor port on the next cycle
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !hit) |=> !cpu_ready);

    // R11: a pending memory word holds its request until acknowledged
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: offsets climb by one between acknowledged words of a burst
    p_ascend_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFF_W-1:0] != LAST_OFF))
            |=> (mem_req && (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1))));

    // R7: the last writeback word hands over to reads
    p_evict_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EVICT) && last_beat) |=> ((state_q == ST_REFILL) && !mem_we));
endmodule

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache #(
    parameter int TAG_W  = 6,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr
);
    logic              hit, hit_way, vict_way, vict_valid, vict_dirty;
    logic [TAG_W-1:0]  vict_tag, fill_tag;
    logic [SET_W-1:0]  upd_set, rd_set, wr_set;
    logic              upd_way, op_touch, op_dirty, op_drop, op_fill, fill_dirty;
    logic              rd_way, wr_en, wr_way;
    logic [OFF_W-1:0]  rd_off, wr_off;
    logic [DATA_W-1:0] rd_data, wr_data;

    wbc_tag_array #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (cpu_addr[OFF_W +: SET_W]),
        .lk_tag     (cpu_addr[ADDR_W-1 -: TAG_W]),
        .hit        (hit),
        .hit_way    (hit_way),
        .vict_way   (vict_way),
        .vict_valid (vict_valid),
        .vict_dirty (vict_dirty),
        .vict_tag   (vict_tag),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .op_touch   (op_touch),
        .op_dirty   (op_dirty),
        .op_drop    (op_drop),
        .op_fill    (op_fill),
        .fill_tag   (fill_tag),
        .fill_dirty (fill_dirty),
        .inv_req    (inv_req),
        .inv_set    (inv_addr[OFF_W +: SET_W]),
        .inv_tag    (inv_addr[ADDR_W-1 -: TAG_W])
    );

    wbc_data_array #(.SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_way  (wr_way),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .rd_set  (rd_set),
        .rd_way  (rd_way),
        .rd_off  (rd_off),
        .rd_data (rd_data)
    );

    wbc_ctrl #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .hit        (hit),
        .hit_way    (hit_way),
        .vict_way   (vict_way),
        .vict_valid (vict_valid),
        .vict_dirty (vict_dirty),
        .vict_tag   (vict_tag),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .op_touch   (op_touch),
        .op_dirty   (op_dirty),
        .op_drop    (op_drop),
        .op_fill    (op_fill),
        .fill_tag   (fill_tag),
        .fill_dirty (fill_dirty),
        .rd_set     (rd_set),
        .rd_way     (rd_way),
        .rd_off     (rd_off),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .wr_way     (wr_way),
        .wr_off     (wr_off),
        .wr_data    (wr_data)
    );
endmodule

// File: tb/twoway_wb_cache_tb.sv
module twoway_wb_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        inv_req = 1'b0;
    logic [15:0] inv_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twoway_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .inv_req(inv_req), .inv_addr(inv_addr)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    // reference model of the cache state and of the two views of memory
    bit [5:0]    m_tag   [64][2];
    bit          m_val   [64][2];
    bit          m_dirty [64][2];
    bit          m_lru   [64];
    logic [15:0] ref_m [int];   // value the processor must see
    logic [15:0] em_m  [int];   // value main memory must hold
    logic [15:0] mm_m  [int];   // responder storage

    // current operation
    bit          op_active = 0, op_read = 0, op_hit = 0, got_rvalid = 0;
    logic [15:0] exp_rdata;
    int          exp_nwb = 0, exp_total = 0, crit_ack = 0;
    int          ack_cnt = 0, wr_cnt = 0, drive_cyc = 0;
    logic [5:0]  exp_tag, exp_vtag, exp_set;

    function automatic logic [15:0] init_word(int a);
        return 16'(a * 37 + 16'h01d3);
    endfunction
    function automatic logic [15:0] get_ref(int a);
        return ref_m.exists(a) ? ref_m[a] : init_word(a);
    endfunction
    function automatic logic [15:0] get_em(int a);
        return em_m.exists(a) ? em_m[a] : init_word(a);
    endfunction
    function automatic logic [15:0] get_mm(int a);
        return mm_m.exists(a) ? mm_m[a] : init_word(a);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor and memory responder, away from the active edge
    always @(negedge clk) begin
        if (cyc >= WD_LIMIT && !finished) begin
            finished = 1;
            chk(0, "R9", "watchdog expired", cyc, WD_LIMIT);
            summary();
            $finish;
        end
        if (cpu_rvalid) begin
            if (!op_active || !op_read || got_rvalid) begin
                chk(0, "R8", "unexpected read return", 1, 0);
            end else begin
                got_rvalid = 1;
                chk(cpu_rdata == exp_rdata, op_hit ? "R3" : "R5", "read data",
                    cpu_rdata, exp_rdata);
                if (op_hit)
                    chk(cyc == drive_cyc + 1, "R3", "hit latency", cyc - drive_cyc, 1);
                else
                    chk(ack_cnt == crit_ack, "R5", "acks before critical word",
                        ack_cnt, crit_ack);
            end
        end
        mem_ack = 1'b0;
        if (mem_req && ($urandom % 3 != 0)) begin
            logic [15:0] ea;
            bit          ewe;
            ewe = (ack_cnt < exp_nwb);
            if (ewe) ea = {exp_vtag, exp_set, 4'(ack_cnt)};
            else     ea = {exp_tag, exp_set, 4'(ack_cnt - exp_nwb)};
            if (!op_active)
                chk(0, "R11", "memory request while idle", 1, 0);
            chk(mem_addr == ea, ewe ? "R7" : "R12", "memory address order", mem_addr, ea);
            chk(mem_we == ewe, "R7", "writeback before refill", mem_we, ewe);
            if (mem_we) begin
                chk(mem_wdata == get_em(int'(mem_addr)), "R4", "written-back data",
                    mem_wdata, get_em(int'(mem_addr)));
                mm_m[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = get_mm(int'(mem_addr));
            end
            mem_ack = 1'b1;
            ack_cnt++;
        end
    end

    task automatic do_op(input bit we, input logic [15:0] a, input logic [15:0] wd);
        logic [5:0] s, t;
        logic [3:0] o;
        int hitw, v;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        s = a[9:4]; t = a[15:10]; o = a[3:0];
        hitw = -1;
        for (int w = 0; w < 2; w++)
            if (m_val[s][w] && m_tag[s][w] == t) hitw = w;
        exp_set = s; exp_tag = t;
        ack_cnt = 0; wr_cnt = 0; got_rvalid = 0;
        if (hitw >= 0) begin
            op_hit = 1;
            m_lru[s] = (hitw == 0);
            exp_nwb = 0; exp_total = 0;
            if (we) begin
                m_dirty[s][hitw] = 1;
                ref_m[int'(a)] = wd;
            end
        end else begin
            op_hit = 0;
            v = !m_val[s][0] ? 0 : (!m_val[s][1] ? 1 : int'(m_lru[s]));
            exp_vtag = m_tag[s][v];
            exp_nwb = (m_val[s][v] && m_dirty[s][v]) ? 16 : 0;
            if (exp_nwb != 0)
                for (int k = 0; k < 16; k++)
                    em_m[int'({exp_vtag, s, 4'(k)})] = get_ref(int'({exp_vtag, s, 4'(k)}));
            m_tag[s][v] = t; m_val[s][v] = 1; m_dirty[s][v] = we; m_lru[s] = (v == 0);
            if (we) ref_m[int'(a)] = wd;
            exp_total = exp_nwb + 16;
            crit_ack = exp_nwb + int'(o) + 1;
        end
        exp_rdata = get_ref(int'(a));
        op_read = !we;
        op_active = 1;
        drive_cyc = cyc;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (op_hit) chk(cpu_ready == 1'b1, "R3", "ready after hit", cpu_ready, 1);
        else        chk(cpu_ready == 1'b0, "R9", "ready during miss", cpu_ready, 0);
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        if (!we) chk(got_rvalid, op_hit ? "R3" : "R5", "read returned", got_rvalid, 1);
        chk(ack_cnt == exp_total, op_hit ? (we ? "R4" : "R3") : (we ? "R8" : "R6"),
            "memory words for access", ack_cnt, exp_total);
        chk(wr_cnt == exp_nwb, "R7", "writeback words", wr_cnt, exp_nwb);
        op_active = 0;
    endtask

    task automatic inv_op(input logic [15:0] a);
        logic [5:0] s, t;
        @(negedge clk);
        s = a[9:4]; t = a[15:10];
        for (int w = 0; w < 2; w++) begin
            if (m_val[s][w] && m_tag[s][w] == t) begin
                if (m_dirty[s][w])
                    for (int k = 0; k < 16; k++)
                        ref_m[int'({t, s, 4'(k)})] = get_em(int'({t, s, 4'(k)}));
                m_val[s][w] = 0;
                m_dirty[s][w] = 0;
            end
        end
        inv_req = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_req = 1'b0;
    endtask

    function automatic logic [15:0] rand_addr();
        logic [5:0] s;
        case ($urandom % 4)
            0: s = 6'd0;
            1: s = 6'd1;
            2: s = 6'd2;
            default: s = 6'd63;
        endcase
        return {6'($urandom % 4), s, 4'($urandom % 16)};
    endfunction

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
        chk(mem_req == 1'b0, "R1", "no memory request after reset", mem_req, 0);
        chk(cpu_rvalid == 1'b0, "R1", "no read return after reset", cpu_rvalid, 0);

        do_op(0, 16'h0000, '0);          // R1 R5 R12: cold miss, first word critical
        do_op(0, 16'h000F, '0);          // R3: hit on the line just filled
        do_op(1, 16'h0005, 16'hBEEF);    // R4: write hit
        do_op(0, 16'h0400, '0);          // R6: fills the empty way 1
        do_op(0, 16'h0005, '0);          // R4: written word readable, way 0 touched
        do_op(0, 16'h0803, '0);          // R6 R7: clean LRU victim, no writes
        do_op(0, 16'h0C0F, '0);          // R7 R5 R2: dirty victim written back, last word critical
        do_op(0, 16'h0005, '0);          // R7: evicted data comes back from memory
        do_op(1, 16'h1234, 16'h1111);    // R8: write miss allocates
        do_op(0, 16'h1234, '0);          // R8: written word held after refill
        inv_op(16'h1230);                // R10: offset ignored, dirty line dropped
        do_op(0, 16'h1234, '0);          // R10: miss, memory value returned
        inv_op(16'hFC00);                // R10: no resident match, no effect
        do_op(0, 16'h0C00, '0);          // R10: still a hit

        for (int i = 0; i < 400; i++) begin
            if ($urandom % 10 == 0)
                inv_op(rand_addr());
            else
                do_op(1'($urandom % 2), rand_addr(), 16'($urandom));
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule